// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital controller that steps a successive-approximation converter through its convert and acquire phases. A falling edge on the active-low start input begins a conversion. Busy is held high for a fixed number of clocks. When busy drops, the word from the comparator model is captured and a one-cycle valid strobe is issued. Phase lengths are clock counts that are set by parameters.

There are three operating modes. In normal and warp mode, every conversion needs a new start edge. In impulse mode, holding the start input low makes the sequencer run the acquisition phase itself and then restart, repeating for as long as the input stays low. Impulse mode also drops the block into low power after each conversion. A power-down request never cuts a conversion short. It takes effect once busy has fallen, and it blocks new starts while it is held.

Top module: `sar_seq_top`

## Requirements
- R1: A conversion begins only on a high-to-low transition of `start_n`. Busy is high on the cycle after the clock that first samples `start_n` low, and one edge yields exactly one conversion.
- R2: Each conversion keeps `busy` high for exactly CONV_CYCLES consecutive clocks.
- R3: While busy is high, toggling `start_n` neither extends nor restarts the running conversion, and a start edge seen during a conversion is discarded.
- R4: Raising `pwr_dn` during a conversion does not shorten it. While `pwr_dn` is high and busy is low, no conversion starts and `low_pwr` is high.
- R5: In impulse mode (`mode_sel` = 2'b10), if `start_n` is low on the clock busy falls, busy stays low for exactly ACQ_CYCLES clocks and then a new conversion starts. This repeats until `start_n` is high when busy falls.
- R6: In normal (2'b00) and warp (2'b01) mode, a `start_n` held low after a conversion does not start another. Code 2'b11 behaves as normal.
- R7: Reset clears `busy`, `res_vld`, `low_pwr` and `res_word`. After reset, a `start_n` that stayed low through reset does not start a conversion until it has been high and then low again.
- R8: After an impulse-mode conversion, `low_pwr` is high from the clock busy falls through acquisition and idle. It is low whenever busy is high.
- R9: `res_word` loads `data_in` and `res_vld` is high for one cycle on exactly the clock where busy falls. Otherwise `res_word` holds its value.
- R10: `mode_sel` is sampled only when a conversion begins, including an automatic restart. Changing it mid-conversion affects only the next conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_n | input | 1 | Active-low conversion start |
| pwr_dn | input | 1 | Power-down request |
| mode_sel | input | 2 | 00 normal, 01 warp, 10 impulse, 11 normal |
| data_in | input | DATA_W | Result from the comparator model |
| busy | output | 1 | Conversion in progress |
| low_pwr | output | 1 | Low-power enable |
| res_vld | output | 1 | One-cycle result strobe |
| res_word | output | DATA_W | Latched conversion result |

## Verification
A start edge applied before a clock is first visible as busy one clock later. Busy then stays high for CONV_CYCLES clocks. The strobe and the new word appear on the first clock with busy low, and an impulse restart raises busy again after exactly ACQ_CYCLES low clocks. The bench drives inputs and samples outputs on falling clock edges. It counts busy, gap and strobe cycles one falling edge at a time, so every comparison falls on the exact cycle these counts predict. Checks that something is ignored watch busy over a fixed window long enough to cover any restart that should not happen.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_CONV = 2'b01,
    PH_ACQ  = 2'b10
  } phase_t;

  localparam logic [1:0] MODE_NORMAL  = 2'b00;
  localparam logic [1:0] MODE_WARP    = 2'b01;
  localparam logic [1:0] MODE_IMPULSE = 2'b10;

endpackage

// File: rtl/sar_start_edge.sv
module sar_start_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic start_n,
  output logic start_fall
);

  // Cleared by reset so that a start held low through reset is not an edge
  logic was_high_q;
  logic was_high_d;

  always_comb begin
    was_high_d = start_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      was_high_q <= 1'b0;
    end else begin
      was_high_q <= was_high_d;
    end
  end

  assign start_fall = was_high_q & ~start_n;

endmodule

// File: rtl/sar_phase_cnt.sv
module sar_phase_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (en) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/sar_result_reg.sv
module sar_result_reg #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              vld
);

  logic [DATA_W-1:0] word_q;
  logic [DATA_W-1:0] word_d;
  logic              vld_q;

  always_comb begin
    word_d = word_q;
    if (load) begin
      word_d = din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      word_q <= word_d;
      vld_q  <= load;
    end
  end

  assign dout = word_q;
  assign vld  = vld_q;

endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top #(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 8,
  parameter int ACQ_CYCLES  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_n,
  input  logic              pwr_dn,
  input  logic [1:0]        mode_sel,
  input  logic [DATA_W-1:0] data_in,
  output logic              busy,
  output logic              low_pwr,
  output logic              res_vld,
  output logic [DATA_W-1:0] res_word
);
  import sar_seq_pkg::*;

  localparam int MAX_PH = (CONV_CYCLES > ACQ_CYCLES) ? CONV_CYCLES : ACQ_CYCLES;
  localparam int CNT_W  = $clog2(MAX_PH + 1);
  localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_CYCLES - 1);
  localparam logic [CNT_W-1:0] ACQ_LAST  = CNT_W'(ACQ_CYCLES - 1);

  phase_t           phase_q, phase_d;
  logic [1:0]       mode_q, mode_d;
  logic             start_fall;
  logic             cnt_clr;
  logic             cnt_en;
  logic [CNT_W-1:0] cnt;
  logic             load;
  logic             conv_last;
  logic             acq_last;
  logic             impulse_q;

  sar_start_edge u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_n    (start_n),
    .start_fall (start_fall)
  );

  sar_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .en    (cnt_en),
    .cnt   (cnt)
  );

  sar_result_reg #(.DATA_W(DATA_W)) u_res (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .din   (data_in),
    .dout  (res_word),
    .vld   (res_vld)
  );

  assign conv_last = (cnt == CONV_LAST);
  assign acq_last  = (cnt == ACQ_LAST);
  assign impulse_q = (mode_q == MODE_IMPULSE);
  assign cnt_en    = (phase_q != PH_IDLE);

  always_comb begin
    phase_d = phase_q;
    mode_d  = mode_q;
    cnt_clr = 1'b0;
    load    = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (start_fall && !pwr_dn) begin
          phase_d = PH_CONV;
          mode_d  = mode_sel;
          cnt_clr = 1'b1;
        end
      end
      PH_CONV: begin
        if (conv_last) begin
          load    = 1'b1;
          cnt_clr = 1'b1;
          if (impulse_q && !start_n && !pwr_dn) begin
            phase_d = PH_ACQ;
          end else begin
            phase_d = PH_IDLE;
          end
        end
      end
      PH_ACQ: begin
        if (pwr_dn) begin
          phase_d = PH_IDLE;
          cnt_clr = 1'b1;
        end else if (acq_last) begin
          phase_d = PH_CONV;
          mode_d  = mode_sel;
          cnt_clr = 1'b1;
        end
      end
      default: begin
        phase_d = PH_IDLE;
        cnt_clr = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      mode_q  <= MODE_NORMAL;
    end else begin
      phase_q <= phase_d;
      mode_q  <= mode_d;
    end
  end

  assign busy    = (phase_q == PH_CONV);
  assign low_pwr = (phase_q != PH_CONV) && (pwr_dn || impulse_q);

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_dn,
  input logic              busy,
  input logic              low_pwr,
  input logic              res_vld,
  input logic [DATA_W-1:0] res_word
);

  int run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 0;
    end else if (busy) begin
      run_q <= run_q + 1;
    end else begin
      run_q <= 0;
    end
  end

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> run_q == CONV_CYCLES); // R2
  AST_VLD_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> res_vld); // R9
  AST_VLD_ONLY_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n) res_vld |-> $fell(busy)); // R9
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !res_vld |-> $stable(res_word)); // R9
  AST_NO_START_IN_PDN: assert property (@(posedge clk) disable iff (!rst_n) (!busy && pwr_dn) |=> !busy); // R4
  AST_LP_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) low_pwr |-> !busy); // R8

endmodule

bind sar_seq_top sar_seq_chk #(
  .DATA_W      (DATA_W),
  .CONV_CYCLES (CONV_CYCLES)
) u_sar_seq_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pwr_dn   (pwr_dn),
  .busy     (busy),
  .low_pwr  (low_pwr),
  .res_vld  (res_vld),
  .res_word (res_word)
);

// File: tb/test_sar_seq_top.sv
module test_sar_seq_top;

  localparam int DW   = 16;
  localparam int CONV = 8;
  localparam int ACQ  = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_n;
  logic          pwr_dn;
  logic [1:0]    mode_sel;
  logic [DW-1:0] data_in;
  logic          busy;
  logic          low_pwr;
  logic          res_vld;
  logic [DW-1:0] res_word;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  sar_seq_top #(.DATA_W(DW), .CONV_CYCLES(CONV), .ACQ_CYCLES(ACQ)) i_sar_seq_top (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_n  (start_n),
    .pwr_dn   (pwr_dn),
    .mode_sel (mode_sel),
    .data_in  (data_in),
    .busy     (busy),
    .low_pwr  (low_pwr),
    .res_vld  (res_vld),
    .res_word (res_word)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic run_conv(output int len);
    len = 0;
    while (busy && len < 200) begin
      len++;
      tick();
    end
  endtask

  task automatic busy_window(input int cycles, output int hits);
    hits = 0;
    for (int k = 0; k < cycles; k++) begin
      hits += int'(busy);
      tick();
    end
  endtask

  task automatic t_power_up();
    int hits;
    chk("R7", "busy in reset", int'(busy), 0);
    chk("R7", "res_word in reset", int'(res_word), 0);
    chk("R7", "res_vld in reset", int'(res_vld), 0);
    chk("R7", "low_pwr in reset", int'(low_pwr), 0);
    rst_n = 1'b1;
    busy_window(10, hits);
    chk("R7", "busy cycles with start idle", hits, 0);
  endtask

  task automatic t_single();
    int len;
    mode_sel = 2'b00; data_in = 16'hA5A5;
    start_n = 1'b0; tick();
    chk("R1", "busy after edge", int'(busy), 1);
    start_n = 1'b1;
    run_conv(len);
    chk("R2", "busy length", len, CONV);
    chk("R9", "res_vld at busy fall", int'(res_vld), 1);
    chk("R9", "res_word at busy fall", int'(res_word), 16'hA5A5);
    data_in = 16'h1234; tick();
    chk("R9", "res_vld one cycle", int'(res_vld), 0);
    repeat (15) tick();
    chk("R9", "res_word held", int'(res_word), 16'hA5A5);
    chk("R1", "single conversion per edge", int'(busy), 0);
    chk("R8", "low_pwr after normal", int'(low_pwr), 0);
  endtask

  task automatic t_ignore_start();
    int bc = 0;
    int vc = 0;
    mode_sel = 2'b00; data_in = 16'h00FF;
    start_n = 1'b0; tick();
    for (int k = 0; k < 6; k++) begin
      bc += int'(busy); vc += int'(res_vld);
      start_n = (k % 2 == 1);
      tick();
    end
    start_n = 1'b1;
    for (int k = 0; k < 14; k++) begin
      bc += int'(busy); vc += int'(res_vld);
      tick();
    end
    chk("R3", "busy cycles with toggling start", bc, CONV);
    chk("R3", "strobes with toggling start", vc, 1);
  endtask

  task automatic t_no_auto(input logic [1:0] m);
    int len;
    int hits;
    mode_sel = m; data_in = 16'h0101;
    start_n = 1'b0; tick();
    run_conv(len);
    chk("R6", "busy length", len, CONV);
    busy_window(20, hits);
    chk("R6", "no restart with start held", hits, 0);
    start_n = 1'b1; tick();
  endtask

  task automatic t_impulse();
    int len;
    int gap = 0;
    int lp_bad = 0;
    int hits;
    mode_sel = 2'b10; data_in = 16'h0F0F;
    start_n = 1'b0; tick();
    chk("R8", "low_pwr while busy", int'(low_pwr), 0);
    run_conv(len);
    chk("R5", "first busy length", len, CONV);
    chk("R9", "first word", int'(res_word), 16'h0F0F);
    data_in = 16'hF0F0;
    while (!busy && gap < 50) begin
      if (!low_pwr) lp_bad++;
      gap++;
      tick();
    end
    chk("R5", "acquisition gap", gap, ACQ);
    chk("R8", "low_pwr drops in gap", lp_bad, 0);
    chk("R8", "low_pwr in second conversion", int'(low_pwr), 0);
    start_n = 1'b1;
    run_conv(len);
    chk("R5", "second busy length", len, CONV);
    chk("R9", "second word", int'(res_word), 16'hF0F0);
    busy_window(15, hits);
    chk("R5", "stops when start high", hits, 0);
    chk("R8", "low_pwr held in idle", int'(low_pwr), 1);
  endtask

  task automatic t_power_down();
    int len;
    int hits;
    mode_sel = 2'b00;
    start_n = 1'b0; tick();
    start_n = 1'b1; pwr_dn = 1'b1;
    chk("R4", "low_pwr during conversion", int'(low_pwr), 0);
    run_conv(len);
    chk("R4", "busy length with power-down", len, CONV);
    start_n = 1'b0; tick();
    start_n = 1'b1;
    busy_window(10, hits);
    chk("R4", "no start in power-down", hits, 0);
    chk("R4", "low_pwr in power-down", int'(low_pwr), 1);
    pwr_dn = 1'b0; tick();
    chk("R4", "low_pwr released", int'(low_pwr), 0);
  endtask

  task automatic t_mode_sample();
    int len;
    int gap = 0;
    int hits;
    mode_sel = 2'b10;
    start_n = 1'b0; tick();
    mode_sel = 2'b00;
    run_conv(len);
    while (!busy && gap < 50) begin
      gap++;
      tick();
    end
    chk("R10", "impulse kept after mid change", gap, ACQ);
    run_conv(len);
    chk("R10", "restart busy length", len, CONV);
    busy_window(15, hits);
    chk("R10", "restart sampled normal", hits, 0);
    start_n = 1'b1; tick();
    mode_sel = 2'b00;
    start_n = 1'b0; tick();
    mode_sel = 2'b10;
    run_conv(len);
    busy_window(15, hits);
    chk("R10", "normal kept after mid change", hits, 0);
    start_n = 1'b1; mode_sel = 2'b00; tick();
  endtask

  task automatic t_reset_rearm();
    int len;
    int hits;
    start_n = 1'b0; rst_n = 1'b0; tick();
    chk("R7", "res_word cleared", int'(res_word), 0);
    chk("R7", "busy cleared", int'(busy), 0);
    rst_n = 1'b1;
    busy_window(10, hits);
    chk("R7", "no start from held-low input", hits, 0);
    start_n = 1'b1; tick();
    start_n = 1'b0; tick();
    chk("R7", "start after fresh edge", int'(busy), 1);
    start_n = 1'b1;
    run_conv(len);
    chk("R2", "busy length after reset", len, CONV);
  endtask

  initial begin
    rst_n = 1'b0; start_n = 1'b1; pwr_dn = 1'b0;
    mode_sel = 2'b00; data_in = '0;
    repeat (3) tick();
    t_power_up();
    t_single();
    t_ignore_start();
    t_no_auto(2'b00);
    t_no_auto(2'b01);
    t_impulse();
    t_power_down();
    t_mode_sample();
    t_reset_rearm();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule